// File: doc/BRIEF.md
# Two-Wire Debug Host Transaction Engine

This block is the probe side of a two-wire serial debug link. It produces the serial clock and drives or releases a single bidirectional data line through an output-enable. One request on the command interface runs one complete register transaction on the link. A request names a debug-port or access-port register, a direction, a 2-bit register address and, for writes, a 32-bit word.

The engine sends the 8-bit request header and leaves the line idle for one turnaround clock. It then reads the target's 3-bit response code. On an OK response it moves 32 data bits and a parity bit. The target sends them on a read and the host sends them on a write. Any other response skips the data phase. When the engine finishes, it pulses `done` and presents the response code, the read word and two error flags. These stay valid until the next transaction completes. Retrying after WAIT is left to the logic that issues commands.

Top module: `swd_host_engine`

## Requirements
- R1: The request header is 8 bits, sent least significant bit first with the output-enable high. Bit 0 is a start bit of 1. Bit 1 is the port select (1 = access port). Bit 2 is read/write (1 = read). Bits 3 and 4 are address bits 0 and 1. Bit 5 is the XOR of bits 1 to 4. Bit 6 is a stop bit of 0. Bit 7 is a park bit of 1.
- R2: After the header comes one turnaround clock with the output-enable low. The 3-bit response is then sampled on the next three rising clock edges, least significant bit first. The codes are OK = 3'b001, WAIT = 3'b010 and FAULT = 3'b100. `ack_code` reports the received value. The host never enables its driver while the target is driving.
- R3: A read with an OK response samples 32 data bits (least significant first) and then a parity bit from the target. One turnaround clock follows. `rdata` returns the word. The transaction lasts 46 serial clock periods.
- R4: A write with an OK response inserts one turnaround clock after the response. The host then drives the 32 write bits, least significant first, followed by their XOR as the parity bit. The transaction lasts 46 serial clock periods.
- R5: A response other than OK skips the data phase. It is followed by one turnaround clock, giving 13 serial clock periods in all. `rdata` reads 0.
- R6: `proto_err` is set when the response is not one of the three defined codes, and is 0 otherwise.
- R7: `parity_err` is set only for an OK read whose received parity bit differs from the XOR of the 32 received bits. It is 0 for writes and for responses other than OK.
- R8: The serial clock rests low when idle. Each period is HALF_PERIOD system clocks low followed by HALF_PERIOD high. The host changes `swdio_out` and `swdio_oe` only at falling edges and samples `swdio_in` at rising edges.
- R9: `done` is a one-cycle pulse, and `busy` is already low in that cycle. The results hold until the next transaction completes.
- R10: `start` is ignored while `busy` is high. Reset returns the engine to idle with the line released, the clock low and the results cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transaction (accepted when idle) |
| cmd_ap | input | 1 | 1 = access-port register, 0 = debug-port register |
| cmd_rnw | input | 1 | 1 = read, 0 = write |
| cmd_addr | input | 2 | Register address bits |
| cmd_wdata | input | 32 | Word to write |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Word read (0 unless OK read) |
| ack_code | output | 3 | Response code received |
| proto_err | output | 1 | Response code undefined |
| parity_err | output | 1 | Read data parity mismatch |
| swclk | output | 1 | Serial clock to target |
| swdio_out | output | 1 | Data value driven when enabled |
| swdio_oe | output | 1 | Driver enable for the data line |
| swdio_in | input | 1 | Data line as seen at the pin |

## Verification
The bench models a target that responds on the rising serial clock edges. It goes after the places where the line changes hands. A turnaround that is missed or doubled shows up as a wrong period count, as sampling shifted by one bit, or as both sides driving at once. The bench feeds WAIT, FAULT, all-ones and all-zero response codes. A design that ran the data phase anyway would produce 46 periods instead of 13, and one that failed to flag undefined codes would leave `proto_err` low. A read with a corrupted parity bit catches a checker that compares against the wrong polarity. Restarting in mid-transaction and resetting in mid-transaction expose an engine that accepts a second command or fails to release the line.

// File: rtl/swd_host_pkg.sv
package swd_host_pkg;

    localparam int DATA_W   = 32;
    localparam int HDR_BITS = 8;
    localparam int RSP_BITS = 3;
    localparam int CNT_W    = $clog2(DATA_W + 2);

    localparam logic [RSP_BITS-1:0] RSP_OK    = 3'b001;
    localparam logic [RSP_BITS-1:0] RSP_WAIT  = 3'b010;
    localparam logic [RSP_BITS-1:0] RSP_FAULT = 3'b100;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_HDR,
        PH_TRN_HDR,
        PH_RSP,
        PH_RD_DATA,
        PH_TRN_WR,
        PH_WR_DATA,
        PH_TRN_END
    } phase_e;

    typedef struct packed {
        logic              ap;
        logic              rnw;
        logic [1:0]        addr;
        logic [DATA_W-1:0] wdata;
    } cmd_t;

    typedef struct packed {
        logic [DATA_W-1:0]   rdata;
        logic [RSP_BITS-1:0] rsp;
        logic                proto_err;
        logic                parity_err;
    } result_t;

    function automatic logic [HDR_BITS-1:0] make_header(input cmd_t c);
        logic [HDR_BITS-1:0] h;
        h    = '0;
        h[0] = 1'b1;
        h[1] = c.ap;
        h[2] = c.rnw;
        h[3] = c.addr[0];
        h[4] = c.addr[1];
        h[5] = c.ap ^ c.rnw ^ c.addr[0] ^ c.addr[1];
        h[6] = 1'b0;
        h[7] = 1'b1;
        return h;
    endfunction

    function automatic logic word_parity(input logic [DATA_W-1:0] w);
        return ^w;
    endfunction

    function automatic logic rsp_defined(input logic [RSP_BITS-1:0] r);
        return (r == RSP_OK) || (r == RSP_WAIT) || (r == RSP_FAULT);
    endfunction

endpackage

// File: rtl/swd_bit_timer.sv
module swd_bit_timer #(
    parameter int HALF_PERIOD = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic swclk,
    output logic rise_stb,
    output logic end_stb
);
    localparam int PERIOD = 2 * HALF_PERIOD;
    localparam int TW     = (PERIOD > 2) ? $clog2(PERIOD) : 1;
    localparam logic [TW-1:0] RISE_AT = TW'(HALF_PERIOD - 1);
    localparam logic [TW-1:0] END_AT  = TW'(PERIOD - 1);

    logic [TW-1:0] tick;

    assign rise_stb = run && (tick == RISE_AT);
    assign end_stb  = run && (tick == END_AT);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            tick  <= '0;
            swclk <= 1'b0;
        end else begin
            if (end_stb) begin
                tick  <= '0;
                swclk <= 1'b0;
            end else begin
                tick <= tick + 1'b1;
                if (rise_stb) swclk <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/swd_seq.sv
module swd_seq
    import swd_host_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                cmd_rnw,
    input  logic                end_stb,
    input  logic [RSP_BITS-1:0] rsp_rx,
    output phase_e              phase,
    output logic                load,
    output logic                finish,
    output logic                busy,
    output logic                done,
    output logic                rnw_q
);
    localparam logic [CNT_W-1:0] HDR_LAST  = CNT_W'(HDR_BITS - 1);
    localparam logic [CNT_W-1:0] RSP_LAST  = CNT_W'(RSP_BITS - 1);
    localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W);

    logic [CNT_W-1:0] bit_cnt;
    logic             last_bit;
    phase_e           nxt;

    always_comb begin
        unique case (phase)
            PH_HDR:                         last_bit = (bit_cnt == HDR_LAST);
            PH_RSP:                         last_bit = (bit_cnt == RSP_LAST);
            PH_RD_DATA, PH_WR_DATA:         last_bit = (bit_cnt == DATA_LAST);
            PH_TRN_HDR, PH_TRN_WR, PH_TRN_END: last_bit = 1'b1;
            default:                        last_bit = 1'b0;
        endcase
    end

    assign load   = (phase == PH_IDLE) && start;
    assign finish = end_stb && last_bit &&
                    ((phase == PH_TRN_END) || (phase == PH_WR_DATA));
    assign busy   = (phase != PH_IDLE);

    always_comb begin
        nxt = phase;
        if (load) begin
            nxt = PH_HDR;
        end else if (end_stb && last_bit) begin
            unique case (phase)
                PH_HDR:     nxt = PH_TRN_HDR;
                PH_TRN_HDR: nxt = PH_RSP;
                PH_RSP: begin
                    if (rsp_rx != RSP_OK) nxt = PH_TRN_END;
                    else if (rnw_q)       nxt = PH_RD_DATA;
                    else                  nxt = PH_TRN_WR;
                end
                PH_RD_DATA: nxt = PH_TRN_END;
                PH_TRN_WR:  nxt = PH_WR_DATA;
                PH_WR_DATA: nxt = PH_IDLE;
                PH_TRN_END: nxt = PH_IDLE;
                default:    nxt = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            bit_cnt <= '0;
            done    <= 1'b0;
            rnw_q   <= 1'b0;
        end else begin
            phase <= nxt;
            done  <= finish;
            if (load) rnw_q <= cmd_rnw;
            if (load || (end_stb && last_bit)) bit_cnt <= '0;
            else if (end_stb)                  bit_cnt <= bit_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/swd_datapath.sv
module swd_datapath
    import swd_host_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic                finish,
    input  logic                rise_stb,
    input  logic                end_stb,
    input  phase_e              phase,
    input  logic                rnw_q,
    input  cmd_t                cmd,
    input  logic                swdio_in,
    output logic                swdio_out,
    output logic                swdio_oe,
    output logic [RSP_BITS-1:0] rsp_rx,
    output result_t             res
);
    logic [HDR_BITS-1:0] hdr_sh;
    logic [DATA_W:0]     wr_sh;
    logic [DATA_W:0]     rd_sh;
    logic                rd_ok;

    always_comb begin
        unique case (phase)
            PH_HDR:     begin swdio_oe = 1'b1; swdio_out = hdr_sh[0]; end
            PH_WR_DATA: begin swdio_oe = 1'b1; swdio_out = wr_sh[0];  end
            default:    begin swdio_oe = 1'b0; swdio_out = 1'b0;      end
        endcase
    end

    // transmit shifters advance at the falling edge that closes a bit
    always_ff @(posedge clk) begin
        if (rst) begin
            hdr_sh <= '0;
            wr_sh  <= '0;
        end else if (load) begin
            hdr_sh <= make_header(cmd);
            wr_sh  <= {word_parity(cmd.wdata), cmd.wdata};
        end else if (end_stb) begin
            if (phase == PH_HDR)     hdr_sh <= {1'b0, hdr_sh[HDR_BITS-1:1]};
            if (phase == PH_WR_DATA) wr_sh  <= {1'b0, wr_sh[DATA_W:1]};
        end
    end

    // receive shifters capture at the rising edge
    always_ff @(posedge clk) begin
        if (rst || load) begin
            rsp_rx <= '0;
            rd_sh  <= '0;
        end else if (rise_stb) begin
            if (phase == PH_RSP)     rsp_rx <= {swdio_in, rsp_rx[RSP_BITS-1:1]};
            if (phase == PH_RD_DATA) rd_sh  <= {swdio_in, rd_sh[DATA_W:1]};
        end
    end

    assign rd_ok = rnw_q && (rsp_rx == RSP_OK);

    always_ff @(posedge clk) begin
        if (rst) begin
            res <= '0;
        end else if (finish) begin
            res.rsp        <= rsp_rx;
            res.proto_err  <= !rsp_defined(rsp_rx);
            res.rdata      <= rd_ok ? rd_sh[DATA_W-1:0] : '0;
            res.parity_err <= rd_ok && (rd_sh[DATA_W] != word_parity(rd_sh[DATA_W-1:0]));
        end
    end
endmodule

// File: rtl/swd_host_engine.sv
module swd_host_engine
    import swd_host_pkg::*;
#(
    parameter int HALF_PERIOD = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                cmd_ap,
    input  logic                cmd_rnw,
    input  logic [1:0]          cmd_addr,
    input  logic [DATA_W-1:0]   cmd_wdata,
    output logic                busy,
    output logic                done,
    output logic [DATA_W-1:0]   rdata,
    output logic [RSP_BITS-1:0] ack_code,
    output logic                proto_err,
    output logic                parity_err,
    output logic                swclk,
    output logic                swdio_out,
    output logic                swdio_oe,
    input  logic                swdio_in
);
    phase_e              cur_phase;
    logic                load, finish, rnw_q;
    logic                rise_stb, end_stb;
    logic [RSP_BITS-1:0] rsp_rx;
    cmd_t                cmd;
    result_t             res;

    assign cmd = '{ap: cmd_ap, rnw: cmd_rnw, addr: cmd_addr, wdata: cmd_wdata};

    swd_bit_timer #(.HALF_PERIOD(HALF_PERIOD)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .run      (busy),
        .swclk    (swclk),
        .rise_stb (rise_stb),
        .end_stb  (end_stb)
    );

    swd_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .cmd_rnw (cmd_rnw),
        .end_stb (end_stb),
        .rsp_rx  (rsp_rx),
        .phase   (cur_phase),
        .load    (load),
        .finish  (finish),
        .busy    (busy),
        .done    (done),
        .rnw_q   (rnw_q)
    );

    swd_datapath u_dp (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .finish    (finish),
        .rise_stb  (rise_stb),
        .end_stb   (end_stb),
        .phase     (cur_phase),
        .rnw_q     (rnw_q),
        .cmd       (cmd),
        .swdio_in  (swdio_in),
        .swdio_out (swdio_out),
        .swdio_oe  (swdio_oe),
        .rsp_rx    (rsp_rx),
        .res       (res)
    );

    assign rdata      = res.rdata;
    assign ack_code   = res.rsp;
    assign proto_err  = res.proto_err;
    assign parity_err = res.parity_err;
endmodule

// File: rtl/swd_host_engine_chk.sv
module swd_host_engine_chk
    import swd_host_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                start,
    input logic                busy,
    input logic                done,
    input logic [DATA_W-1:0]   rdata,
    input logic [RSP_BITS-1:0] ack_code,
    input logic                parity_err,
    input logic                swclk,
    input logic                swdio_out,
    input logic                swdio_oe,
    input phase_e              cur_phase
);
    // R8
    drive_stable_high_chk: assert property (@(posedge clk) disable iff (rst)
        (swclk && $past(swclk)) |-> ($stable(swdio_out) && $stable(swdio_oe)));

    // R2
    turnaround_release_chk: assert property (@(posedge clk) disable iff (rst)
        (cur_phase == PH_TRN_HDR || cur_phase == PH_TRN_WR || cur_phase == PH_TRN_END)
        |-> !swdio_oe);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy ##1 !done));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!swdio_oe && !swclk));

    // R10
    start_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && start && !done) |=> (busy || done));

    // R5
    non_ok_rdata_chk: assert property (@(posedge clk) disable iff (rst)
        (done && ack_code != RSP_OK) |-> (rdata == '0));

    // R7
    parity_scope_chk: assert property (@(posedge clk) disable iff (rst)
        (done && parity_err) |-> (ack_code == RSP_OK));
endmodule

bind swd_host_engine swd_host_engine_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .busy       (busy),
    .done       (done),
    .rdata      (rdata),
    .ack_code   (ack_code),
    .parity_err (parity_err),
    .swclk      (swclk),
    .swdio_out  (swdio_out),
    .swdio_oe   (swdio_oe),
    .cur_phase  (cur_phase)
);

// File: tb/swd_host_engine_tb.sv
module swd_host_engine_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        cmd_ap = 1'b0, cmd_rnw = 1'b0;
    logic [1:0]  cmd_addr = 2'b00;
    logic [31:0] cmd_wdata = '0;
    logic        busy, done, proto_err, parity_err, swclk, swdio_out, swdio_oe;
    logic [31:0] rdata;
    logic [2:0]  ack_code;
    logic        swdio_in;

    logic tgt_drive = 1'b0, tgt_bit = 1'b0;
    assign swdio_in = tgt_drive ? tgt_bit : 1'b1;

    always #5 clk = ~clk;

    swd_host_engine u_dut (
        .clk(clk), .rst(rst), .start(start), .cmd_ap(cmd_ap), .cmd_rnw(cmd_rnw),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .busy(busy), .done(done),
        .rdata(rdata), .ack_code(ack_code), .proto_err(proto_err),
        .parity_err(parity_err), .swclk(swclk), .swdio_out(swdio_out),
        .swdio_oe(swdio_oe), .swdio_in(swdio_in)
    );

    int n_chk = 0, n_bad = 0;

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // vector: [39] ap, [38] rnw, [37:36] addr, [35:4] data, [3:1] response, [0] corrupt parity
    localparam int NV = 9;
    localparam logic [39:0] VEC [0:NV-1] = '{
        {1'b0, 1'b1, 2'd0, 32'h0BC1_2477, 3'b001, 1'b0},
        {1'b1, 1'b0, 2'd1, 32'hA5A5_0F0F, 3'b001, 1'b0},
        {1'b1, 1'b1, 2'd3, 32'hFFFF_FFFF, 3'b001, 1'b1},
        {1'b0, 1'b0, 2'd2, 32'h1234_5678, 3'b010, 1'b0},
        {1'b1, 1'b1, 2'd2, 32'hDEAD_BEEF, 3'b100, 1'b0},
        {1'b0, 1'b1, 2'd1, 32'h0000_00FF, 3'b111, 1'b0},
        {1'b0, 1'b0, 2'd3, 32'h0000_0000, 3'b001, 1'b0},
        {1'b1, 1'b1, 2'd0, 32'h8000_0001, 3'b001, 1'b0},
        {1'b0, 1'b0, 2'd0, 32'hCAFE_F00D, 3'b000, 1'b0}
    };

    // target model state
    logic        cur_rnw, cur_ok;
    logic [2:0]  cur_rsp;
    logic [32:0] cur_word;
    logic [7:0]  hdr_cap;
    logic [32:0] wr_cap;
    int          rise_n;
    bit          oe_bad, clash;

    function automatic logic exp_oe(input int n);
        if (n <= 8) return 1'b1;
        if (!cur_rnw && cur_ok && n >= 14 && n <= 46) return 1'b1;
        return 1'b0;
    endfunction

    always @(posedge swclk) begin
        rise_n = rise_n + 1;
        if (swdio_oe !== exp_oe(rise_n)) oe_bad = 1'b1;
        if (rise_n >= 1 && rise_n <= 8) hdr_cap[rise_n-1] = swdio_out;
        if (!cur_rnw && cur_ok && rise_n >= 14 && rise_n <= 46) wr_cap[rise_n-14] = swdio_out;
        #1;
        if (rise_n >= 9 && rise_n <= 11) begin
            tgt_drive = 1'b1; tgt_bit = cur_rsp[rise_n-9];
        end else if (cur_rnw && cur_ok && rise_n >= 12 && rise_n <= 44) begin
            tgt_drive = 1'b1; tgt_bit = cur_word[rise_n-12];
        end else begin
            tgt_drive = 1'b0;
        end
    end

    always @(negedge clk) if (tgt_drive && swdio_oe) clash = 1'b1;

    function automatic logic [7:0] exp_hdr(input logic ap, input logic rnw, input logic [1:0] a);
        return {1'b1, 1'b0, ap ^ rnw ^ a[0] ^ a[1], a[1], a[0], rnw, ap, 1'b1};
    endfunction

    task automatic run_vec(input logic [39:0] v, input bit restart);
        logic        ap, rnw, bp;
        logic [1:0]  a;
        logic [31:0] d, exp_rd;
        logic [2:0]  r;
        int          t, exp_rises;
        bit          rok;
        {ap, rnw, a, d, r, bp} = v;
        cur_rnw = rnw; cur_rsp = r; cur_ok = (r == 3'b001);
        cur_word = {(^d) ^ bp, d};
        rise_n = 0; oe_bad = 1'b0; clash = 1'b0; hdr_cap = '0; wr_cap = '0;
        @(negedge clk);
        cmd_ap = ap; cmd_rnw = rnw; cmd_addr = a; cmd_wdata = d; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (restart) begin
            repeat (20) @(negedge clk);
            cmd_ap = ~ap; cmd_rnw = ~rnw; cmd_addr = ~a; cmd_wdata = ~d; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        t = 0;
        while (!done && t < 4000) begin @(negedge clk); t++; end
        check(done === 1'b1, "R9 done seen", {63'd0, done}, 64'd1);
        check(busy === 1'b0, "R9 busy low with done", {63'd0, busy}, 64'd0);
        check(hdr_cap === exp_hdr(ap, rnw, a), "R1 header bits", {56'd0, hdr_cap}, {56'd0, exp_hdr(ap, rnw, a)});
        check(ack_code === r, "R2 response code", {61'd0, ack_code}, {61'd0, r});
        check(!oe_bad, "R2 enable pattern at rising edges", {63'd0, oe_bad}, 64'd0);
        check(!clash, "R2 no drive overlap", {63'd0, clash}, 64'd0);
        rok = cur_ok && rnw;
        exp_rd = rok ? d : 32'd0;
        check(rdata === exp_rd, rok ? "R3 read word" : "R5 rdata zero", {32'd0, rdata}, {32'd0, exp_rd});
        exp_rises = cur_ok ? 46 : 13;
        check(rise_n == exp_rises, cur_ok ? "R3/R4 period count" : "R5 period count",
              64'(rise_n), 64'(exp_rises));
        check(proto_err === !(r == 3'b001 || r == 3'b010 || r == 3'b100), "R6 undefined code flag",
              {63'd0, proto_err}, {63'd0, !(r == 3'b001 || r == 3'b010 || r == 3'b100)});
        check(parity_err === (rok && bp), "R7 parity flag", {63'd0, parity_err}, {63'd0, rok && bp});
        if (!rnw && cur_ok)
            check(wr_cap === {^d, d}, "R4 write bits and parity", {31'd0, wr_cap}, {31'd0, ^d, d});
        @(negedge clk);
        check(!done && rdata === exp_rd && ack_code === r, "R9 single pulse, results held",
              {31'd0, done, rdata}, {32'd0, exp_rd});
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        rise_n = 0; cur_rnw = 0; cur_ok = 0; cur_rsp = 0; cur_word = 0;
        repeat (4) @(negedge clk);
        // R10 reset state
        check(!busy && !done && !swdio_oe && !swclk && rdata == 0 && ack_code == 0,
              "R10 reset state", {58'd0, busy, done, swdio_oe, swclk, ack_code != 0, rdata != 0}, 64'd0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        for (int i = 0; i < NV; i++) run_vec(VEC[i], 1'b0);

        // R8 serial clock shape: low HALF_PERIOD then high HALF_PERIOD
        begin
            int lo, hi;
            @(negedge clk);
            cmd_rnw = 1'b1; cmd_ap = 1'b0; cmd_addr = 0; cur_rnw = 1; cur_ok = 1; cur_rsp = 3'b001;
            cur_word = {1'b0, 32'd0}; rise_n = 0; start = 1'b1;
            @(negedge clk); start = 1'b0;
            lo = 0; hi = 0;
            while (!swclk) begin lo++; @(negedge clk); end
            while (swclk) begin hi++; @(negedge clk); end
            check(lo == 2 && hi == 2, "R8 clock phases", {lo[31:0], hi[31:0]}, {32'd2, 32'd2});
            while (!done) @(negedge clk);
            repeat (3) @(negedge clk);
        end

        // R10 start while busy ignored
        run_vec(VEC[1], 1'b1);
        run_vec(VEC[0], 1'b1);

        // R10 reset in mid-transaction
        @(negedge clk);
        cmd_rnw = 1'b1; cur_rnw = 1; cur_ok = 1; cur_rsp = 3'b001; rise_n = 0; start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (30) @(negedge clk);
        rst = 1'b1;
        @(negedge clk); @(negedge clk);
        check(!busy && !swdio_oe && !swclk && ack_code == 0 && rdata == 0, "R10 reset mid-transaction",
              {60'd0, busy, swdio_oe, swclk, ack_code != 0}, 64'd0);
        rst = 1'b0;
        #2 tgt_drive = 1'b0;
        repeat (3) @(negedge clk);
        run_vec(VEC[7], 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule